// File: doc/BRIEF.md
# Synthesizer Divider and Mode Control

This block is the digital part of a crystal-referenced PLL clock synthesizer, written as single-clock, cycle-based logic. The oscillator, the VCO feedback and an external test clock arrive as one-cycle enable pulses on the system clock. The block divides the oscillator pulses by a fixed ratio to form the phase-detector reference. It divides a selected source by a 9-bit loop value to form the feedback pulse. It also divides a selected source down to a square output clock at one half or one quarter of the source rate.

The loop value comes from a parallel bus through a load register. While the active-low load strobe is low, the register passes the bus straight through. When the strobe returns high, the register keeps the last value it saw. A lock-range flag reports whether the value in use lies in the span where the loop can settle. A two-bit mode input selects between plain and spread clocking, and between two bypass test routings. The new mode applies at once and needs no reset. An active-high reset clears every counter and drives all pulse and clock outputs low.

Top module: `clksyn_divctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ref_pulse`, `fb_pulse` and `out_clk` are low. All counters are cleared and the output ratio register selects divide-by-2.
- R2: `ref_pulse` is high for exactly one cycle. It rises in the cycle after every 16th `osc_en` pulse counted since reset.
- R3: While `load_n` is low, `m_value` equals `m_in` in the same cycle.
- R4: While `load_n` is high, `m_value` holds the `m_in` value seen in the last cycle in which `load_n` was low. Changes on `m_in` have no effect on it.
- R5: `lock_ok` is high exactly when 250 <= `m_value` <= 511.
- R6: `fb_pulse` goes high for one cycle, one cycle after the loop source pulse that brings the count to `m_value`, and the count then restarts. A value of 0 or 1 makes every source pulse terminal. If `m_value` is lowered below the count already reached, the next source pulse is terminal.
- R7: `out_clk` toggles one cycle after every h-th output source pulse, giving a 50% duty cycle. h is 1 when `div_sel` is 0 (divide by 2) and 2 when `div_sel` is 1 (divide by 4).
- R8: A new output ratio is taken only at the toggle where `out_clk` falls, so every full period uses one ratio. After reset the divide-by-2 ratio applies until the first fall.
- R9: Mode code 00 is plain clocking and 01 is spread-enabled clocking. `ssc_on` is high exactly in mode 01 and follows `mode` in the same cycle. Both modes use `vco_en` for the loop and output dividers, and a mode change clears no counter.
- R10: In mode 10, the output divider counts `test_en` pulses instead of `vco_en`. The loop divider still counts `vco_en`.
- R11: In mode 11, both the loop divider and the output divider count `ref_pulse` pulses. The ratio latched at the next fall of `out_clk` is divide-by-2, whatever `div_sel` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high master reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| vco_en | input | 1 | One pulse per VCO feedback cycle |
| test_en | input | 1 | One pulse per external test clock cycle |
| m_in | input | 9 | Parallel loop divider value |
| load_n | input | 1 | Active-low load strobe: low = transparent, high = hold |
| div_sel | input | 1 | Output ratio select: 0 = divide by 2, 1 = divide by 4 |
| mode | input | 2 | 00 plain, 01 spread, 10 external-clock bypass, 11 oscillator bypass |
| ref_pulse | output | 1 | Reference pulse to the phase detector |
| fb_pulse | output | 1 | Loop divider output to the phase detector |
| out_clk | output | 1 | Divided output clock |
| m_value | output | 9 | Loop value in use |
| lock_ok | output | 1 | Loop value lies within the lock range |
| ssc_on | output | 1 | Spread modulation enable |

## Verification
`m_value`, `lock_ok` and `ssc_on` are combinational, so the bench compares them 1 ns after it drives new inputs, in the same cycle. `ref_pulse`, `fb_pulse` and `out_clk` each sit one register after the pulse that causes them. In modes 11, the source is itself the registered `ref_pulse`, which adds a second cycle back to `osc_en`. The bench's behavioural model applies each rising edge to the inputs it saw there. It then compares the registered outputs at the following falling edge, before any input changes.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

   typedef enum logic [1:0] {
      MODE_PLAIN  = 2'b00,
      MODE_SPREAD = 2'b01,
      MODE_EXTBYP = 2'b10,
      MODE_OSCBYP = 2'b11
   } clk_mode_e;

   // loop divider source: oscillator bypass uses the reference pulse
   function automatic logic loop_src(clk_mode_e m, logic vco, logic refp);
      return (m == MODE_OSCBYP) ? refp : vco;
   endfunction

   // output divider source per mode
   function automatic logic out_src(clk_mode_e m, logic vco, logic tst, logic refp);
      case (m)
         MODE_EXTBYP: return tst;
         MODE_OSCBYP: return refp;
         default:     return vco;
      endcase
   endfunction

endpackage

// File: rtl/clksyn_mreg.sv
module clksyn_mreg #(
   parameter int M_W      = 9,
   parameter int LOCK_MIN = 250,
   parameter int LOCK_MAX = 511
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load_n,
   input  logic [M_W-1:0] m_in,
   output logic [M_W-1:0] m_value,
   output logic           lock_ok
);

   logic [M_W-1:0] hold_q;
   logic [31:0]    m_wide;

   initial begin
      assert (M_W >= 1 && M_W <= 31) else $error("M_W out of range");
      assert (LOCK_MIN <= LOCK_MAX) else $error("lock span empty");
   end

   always_ff @(posedge clk) begin
      if (rst)          hold_q <= '0;
      else if (!load_n) hold_q <= m_in;
   end

   assign m_value = load_n ? hold_q : m_in;
   assign m_wide  = 32'(m_value);
   assign lock_ok = (m_wide >= 32'(LOCK_MIN)) && (m_wide <= 32'(LOCK_MAX));

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      load_n |=> (load_n -> $stable(m_value)));  // R4

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> (load_n -> (m_value == $past(m_in))));  // R4

endmodule

// File: rtl/clksyn_refdiv.sv
module clksyn_refdiv #(
   parameter int REF_DIV = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic osc_en,
   output logic ref_pulse
);

   localparam int CNT_W = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_DIV - 1);
   localparam bit   POW2 = ((REF_DIV & (REF_DIV - 1)) == 0);

   logic [CNT_W-1:0] cnt_q;
   logic             term;

   initial assert (REF_DIV >= 2) else $error("REF_DIV must be at least 2");

   assign term = osc_en && (cnt_q == LAST);

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst)         cnt_q <= '0;
            else if (osc_en) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (rst)         cnt_q <= '0;
            else if (term)   cnt_q <= '0;
            else if (osc_en) cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) ref_pulse <= 1'b0;
      else     ref_pulse <= term;
   end

   AST_REF_SINGLE: assert property (@(posedge clk) disable iff (rst)
      ref_pulse |=> !ref_pulse);  // R2

   AST_REF_CAUSE: assert property (@(posedge clk) disable iff (rst)
      ref_pulse |-> $past(osc_en));  // R2

endmodule

// File: rtl/clksyn_loopdiv.sv
module clksyn_loopdiv #(
   parameter int M_W = 9
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           src_pulse,
   input  logic [M_W-1:0] m_value,
   output logic           fb_pulse
);

   logic [M_W-1:0] cnt_q;
   logic [M_W:0]   next_cnt;
   logic           term;

   assign next_cnt = {1'b0, cnt_q} + 1'b1;
   assign term     = next_cnt >= {1'b0, m_value};

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         fb_pulse <= 1'b0;
      end else begin
         fb_pulse <= src_pulse && term;
         if (src_pulse) cnt_q <= term ? '0 : next_cnt[M_W-1:0];
      end
   end

   AST_FB_CAUSE: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |-> $past(src_pulse));  // R6

   AST_FB_RESTART: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |-> (cnt_q == '0));  // R6

endmodule

// File: rtl/clksyn_outdiv.sv
module clksyn_outdiv #(
   parameter int HALF_LO = 1,
   parameter int HALF_HI = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic src_pulse,
   input  logic sel_hi,
   output logic out_clk
);

   localparam int H_W = $clog2(HALF_HI + 1);

   logic [H_W-1:0] cnt_q;
   logic [H_W:0]   next_cnt;
   logic [H_W:0]   half;
   logic           ratio_q;
   logic           term;

   initial assert (HALF_LO >= 1 && HALF_HI >= HALF_LO) else $error("bad half periods");

   assign half     = ratio_q ? (H_W+1)'(HALF_HI) : (H_W+1)'(HALF_LO);
   assign next_cnt = {1'b0, cnt_q} + 1'b1;
   assign term     = src_pulse && (next_cnt >= half);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         out_clk <= 1'b0;
         ratio_q <= 1'b0;
      end else if (src_pulse) begin
         if (term) begin
            cnt_q   <= '0;
            out_clk <= !out_clk;
            if (out_clk) ratio_q <= sel_hi;
         end else begin
            cnt_q <= next_cnt[H_W-1:0];
         end
      end
   end

   AST_OUT_TOGGLE_SRC: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_clk) |-> $past(src_pulse));  // R7

   AST_RATIO_AT_FALL: assert property (@(posedge clk) disable iff (rst)
      !$stable(ratio_q) |-> $fell(out_clk));  // R8

endmodule

// File: rtl/clksyn_divctl.sv
module clksyn_divctl
   import clksyn_pkg::*;
#(
   parameter int M_W      = 9,
   parameter int REF_DIV  = 16,
   parameter int LOCK_MIN = 250,
   parameter int LOCK_MAX = 511
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           osc_en,
   input  logic           vco_en,
   input  logic           test_en,
   input  logic [M_W-1:0] m_in,
   input  logic           load_n,
   input  logic           div_sel,
   input  logic [1:0]     mode,
   output logic           ref_pulse,
   output logic           fb_pulse,
   output logic           out_clk,
   output logic [M_W-1:0] m_value,
   output logic           lock_ok,
   output logic           ssc_on
);

   clk_mode_e mode_e;
   logic      lsrc;
   logic      osrc;
   logic      sel_hi;

   assign mode_e = clk_mode_e'(mode);
   assign ssc_on = (mode_e == MODE_SPREAD);
   assign lsrc   = loop_src(mode_e, vco_en, ref_pulse);
   assign osrc   = out_src(mode_e, vco_en, test_en, ref_pulse);
   assign sel_hi = (mode_e == MODE_OSCBYP) ? 1'b0 : div_sel;

   clksyn_mreg #(.M_W(M_W), .LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX)) u_mreg (
      .clk(clk), .rst(rst), .load_n(load_n), .m_in(m_in),
      .m_value(m_value), .lock_ok(lock_ok)
   );

   clksyn_refdiv #(.REF_DIV(REF_DIV)) u_refdiv (
      .clk(clk), .rst(rst), .osc_en(osc_en), .ref_pulse(ref_pulse)
   );

   clksyn_loopdiv #(.M_W(M_W)) u_loopdiv (
      .clk(clk), .rst(rst), .src_pulse(lsrc), .m_value(m_value), .fb_pulse(fb_pulse)
   );

   clksyn_outdiv #(.HALF_LO(1), .HALF_HI(2)) u_outdiv (
      .clk(clk), .rst(rst), .src_pulse(osrc), .sel_hi(sel_hi), .out_clk(out_clk)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(rst) |-> (!ref_pulse && !fb_pulse && !out_clk));  // R1

   AST_OSCBYP_FB: assert property (@(posedge clk) disable iff (rst)
      (fb_pulse && $past(mode_e == MODE_OSCBYP)) |-> $past(ref_pulse));  // R11

endmodule

// File: tb/clksyn_divctl_bench.sv
module clksyn_divctl_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       osc_en = 1'b0, vco_en = 1'b0, test_en = 1'b0;
   logic [8:0] m_in = '0;
   logic       load_n = 1'b1, div_sel = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       ref_pulse, fb_pulse, out_clk, lock_ok, ssc_on;
   logic [8:0] m_value;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0;

   // behavioural model state
   int  e_refcnt, e_loopcnt, e_outcnt, e_hold;
   bit  e_ref, e_fb, e_out, e_quarter;

   always #5 clk = ~clk;

   clksyn_divctl u_clksyn_divctl (
      .clk(clk), .rst(rst), .osc_en(osc_en), .vco_en(vco_en), .test_en(test_en),
      .m_in(m_in), .load_n(load_n), .div_sel(div_sel), .mode(mode),
      .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .out_clk(out_clk),
      .m_value(m_value), .lock_ok(lock_ok), .ssc_on(ssc_on)
   );

   function automatic int exp_m();
      return load_n ? e_hold : int'(m_in);
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         e_refcnt = 0; e_loopcnt = 0; e_outcnt = 0; e_hold = 0;
         e_ref = 0; e_fb = 0; e_out = 0; e_quarter = 0;
      end else begin
         int  meff;
         bit  old_ref, ls, os;
         meff    = exp_m();
         old_ref = e_ref;
         e_ref   = osc_en && (e_refcnt == 15);
         if (osc_en) e_refcnt = (e_refcnt + 1) % 16;
         ls = (mode == 2'b11) ? old_ref : vco_en;
         os = (mode == 2'b11) ? old_ref : (mode == 2'b10) ? test_en : vco_en;
         e_fb = 0;
         if (ls) begin
            if (e_loopcnt + 1 >= meff) begin e_loopcnt = 0; e_fb = 1; end
            else e_loopcnt++;
         end
         if (os) begin
            if (e_outcnt + 1 >= (e_quarter ? 2 : 1)) begin
               e_outcnt = 0;
               if (e_out) e_quarter = (mode == 2'b11) ? 1'b0 : div_sel;
               e_out = !e_out;
            end else e_outcnt++;
         end
         if (!load_n) e_hold = int'(m_in);
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   string tag = "R1";

   // registered outputs at the falling edge, before new inputs
   task automatic cmp_regs();
      chk("R2", "ref_pulse", int'(ref_pulse), int'(e_ref));
      chk((tag == "R11") ? "R11" : "R6", "fb_pulse", int'(fb_pulse), int'(e_fb));
      chk((tag == "R8" || tag == "R10" || tag == "R11") ? tag : "R7",
          "out_clk", int'(out_clk), int'(e_out));
   endtask

   task automatic cmp_comb();
      chk(load_n ? "R4" : "R3", "m_value", int'(m_value), exp_m());
      chk("R5", "lock_ok", int'(lock_ok), int'(exp_m() >= 250 && exp_m() <= 511));
      chk("R9", "ssc_on", int'(ssc_on), int'(mode == 2'b01));
   endtask

   task automatic step(bit o, bit v, bit t);
      @(negedge clk);
      cmp_regs();
      osc_en = o; vco_en = v; test_en = t;
      #1 cmp_comb();
   endtask

   task automatic run(int n, int po, int pv, int pt);
      for (int i = 0; i < n; i++)
         step(($urandom % 100) < po, ($urandom % 100) < pv, ($urandom % 100) < pt);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=%0d expected=0", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "ref_pulse in reset", int'(ref_pulse), 0);
      chk("R1", "fb_pulse in reset", int'(fb_pulse), 0);
      chk("R1", "out_clk in reset", int'(out_clk), 0);
      rst = 1'b0;
      tag = "R1";
      step(1, 1, 1);

      // R3: transparent load, small M, every pulse present
      tag = "R7";
      load_n = 1'b0; m_in = 9'd3;
      run(60, 100, 100, 0);
      // R4: hold, then scramble bus
      load_n = 1'b1;
      step(1, 1, 0);
      m_in = 9'd300;
      run(40, 100, 100, 0);
      m_in = 9'd7;
      run(20, 60, 70, 0);
      // R8: ratio change to /4 mid-run
      tag = "R8";
      div_sel = 1'b1;
      run(80, 70, 80, 0);
      div_sel = 1'b0;
      run(40, 70, 60, 0);
      div_sel = 1'b1;
      run(40, 70, 90, 0);

      // R5: lock boundaries, transparent
      tag = "R7";
      load_n = 1'b0;
      foreach (m_in[k]) begin end
      m_in = 9'd249; step(1, 1, 0);
      m_in = 9'd250; step(1, 1, 0);
      m_in = 9'd511; step(1, 1, 0);
      m_in = 9'd0;   run(10, 100, 100, 0);   // R6: M=0 every pulse terminal
      m_in = 9'd1;   run(10, 100, 50, 0);
      m_in = 9'd9;   run(6, 100, 100, 0);
      m_in = 9'd2;   run(10, 100, 100, 0);   // R6: lowered below count
      m_in = 9'd5;
      load_n = 1'b1;

      // R9: spread mode on the fly, no reset
      mode = 2'b01;
      run(60, 80, 80, 30);
      mode = 2'b00;
      run(20, 80, 80, 30);

      // R10: external test clock bypass
      tag = "R10";
      mode = 2'b10;
      run(120, 80, 60, 40);

      // R11: oscillator divider bypass
      tag = "R11";
      mode = 2'b11;
      div_sel = 1'b1;
      load_n = 1'b0; m_in = 9'd2; step(1, 0, 0);
      load_n = 1'b1;
      run(400, 100, 50, 50);

      // back to plain mode with /4 pending
      tag = "R8";
      mode = 2'b00;
      run(120, 90, 80, 0);

      // reset again mid-stream
      tag = "R1";
      rst = 1'b1;
      step(1, 1, 1);
      step(1, 1, 1);
      rst = 1'b0;
      chk("R1", "out_clk after reset", int'(out_clk), 0);
      tag = "R7";
      run(50, 90, 90, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule